// File: doc/BRIEF.md
# UART Register File and Interrupt Controller

This block is the register-side front end of a 16550-style serial port on a simple peripheral bus. A host reaches eight byte-wide registers, one per 32-bit word, through a strobed access port. Each clock cycle in which both the select and the strobe inputs are high is one access. Reads return data combinationally during the access cycle. Writes take effect at the clock edge that ends the access.

The block holds the interrupt enables, the line and modem control bytes, a scratch byte, a FIFO-mode flag and the two divisor bytes. It latches receive errors and modem-line changes until software reads them. It ranks four interrupt sources and raises a single active-high request. The receive path, the transmit path and the baud generator sit outside the block. They report through level and pulse inputs. The block talks back to them through a pop pulse for the receive buffer, a push pulse with a data byte for the transmit buffer, and the divisor and frame-configuration outputs.

Top module: `uart_regif`

## Requirements
- R1: The register offset is `addr[5:2]`. Offsets 0 to 7 reach registers. Offsets 8 to 15 read as 0x00, and writes to them change nothing.
- R2: An access happens only in a cycle where `sel` and `strobe` are both high. `write` high means a write. `rdata` is 0x00 in any cycle that is not a read access.
- R3: While `rst_n` is low, the block is held in reset at once, and it leaves reset two clock edges after `rst_n` rises. Reset clears the interrupt enables, the line control, modem control, scratch and FIFO-mode registers, the latched errors and the modem deltas. It drives `rts_n` and `dtr_n` high and `irq` low. The divisor bytes and the transmit byte keep their values.
- R4: When line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. `divisor` = {high, low}. `frame_cfg` carries line-control bits 6:0. When bit 7 is clear, offset 1 is the enable register.
- R5: A read of offset 0 with line-control bit 7 clear returns `rx_data`. It also makes `rx_pop` high for exactly the one cycle after the access. A divisor read makes no pop.
- R6: A write of offset 0 with line-control bit 7 clear loads `tx_data`. It also makes `tx_push` high for exactly the one cycle after the access.
- R7: The enable register (offset 1, bits 3:0) has these bits: bit 0 enables receive data or timeout, bit 1 enables transmit empty, bit 2 enables line status, bit 3 enables modem status. `irq` is high exactly when an enabled source is active.
- R8: The identification register (read at offset 2) shows the highest-ranked pending source in bits 3:0. The codes, from highest to lowest rank, are: line status 0x6, timeout 0xC, receive data 0x4, transmit empty 0x2, modem 0x0, none 0x1. Bits 7:6 read 11 in FIFO mode and 00 otherwise.
- R9: The timeout source counts only in FIFO mode. FIFO mode is bit 0 of a write to offset 2.
- R10: The line status register (offset 5) is laid out as: bit 0 `rx_ready`, bits 4:1 latched `err_set[3:0]`, bit 5 `thr_empty`, bit 6 `tx_idle`, bit 7 the OR of the latched errors. Reading it clears the latched errors. A new error arriving in the same cycle wins. The line-status source is any latched error.
- R11: The modem status register (offset 6) puts `modem_in[3:0]` in bits 7:4 and latched deltas in bits 3:0. Bits 0, 1 and 3 latch any change of `modem_in` bits 0, 1 and 3. Bit 2 latches a high-to-low change of `modem_in[2]`. Reading the register clears the deltas. The modem source is any latched delta.
- R12: A transmit-empty pending flag sets when `thr_empty` rises, or when enable bit 1 goes from 0 to 1 while `thr_empty` is high. It clears on a write of the transmit byte, or on an identification read that reports code 0x2.
- R13: The modem control register (offset 4, bits 4:0) drives `dtr_n` = not bit 0 and `rts_n` = not bit 1. The scratch register (offset 7) reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| sel | input | 1 | Block select |
| strobe | input | 1 | Access strobe |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Word address bits 5:2 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during a read access |
| rx_data | input | 8 | Byte at the head of the receive buffer |
| rx_ready | input | 1 | Receive data available |
| rx_timeout | input | 1 | Character timeout from the receive path |
| err_set | input | 4 | Error pulses: overrun, parity, framing, break |
| thr_empty | input | 1 | Transmit holding space free |
| tx_idle | input | 1 | Transmitter fully idle |
| modem_in | input | 4 | Modem lines: CTS, DSR, RI, DCD (bits 0..3) |
| rx_pop | output | 1 | Pop pulse to the receive buffer |
| tx_push | output | 1 | Push pulse to the transmit buffer |
| tx_data | output | 8 | Byte written for transmission |
| divisor | output | 16 | Baud divisor |
| frame_cfg | output | 7 | Line control bits 6:0 (bit 6 = break) |
| fifo_en | output | 1 | FIFO mode |
| rts_n | output | 1 | Request to send, active low |
| dtr_n | output | 1 | Data terminal ready, active low |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a six-bit address (4-bit offset field) and a two-stage reset release. The offset field is wide enough that the unmapped words 8 to 15 can be reached and checked for aliasing onto real registers. The two-stage release fixes when accesses after reset first take effect. With these values, every source priority pairing used, the divisor-bank switch, the edge cases of the transmit-empty latch and the survival of the divisor across reset can all be reached with short directed sequences.

// File: rtl/uart_regif_pkg.sv
`timescale 1ns/1ps
package uart_regif_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    OFS_DATA = 3'd0, OFS_IER = 3'd1, OFS_IIR = 3'd2, OFS_LCR = 3'd3,
    OFS_MCR  = 3'd4, OFS_LSR = 3'd5, OFS_MSR = 3'd6, OFS_SCR = 3'd7
  } reg_ofs_e;

  localparam logic [3:0] IID_NONE    = 4'b0001;
  localparam logic [3:0] IID_LINE    = 4'b0110;
  localparam logic [3:0] IID_TIMEOUT = 4'b1100;
  localparam logic [3:0] IID_RXDATA  = 4'b0100;
  localparam logic [3:0] IID_THRE    = 4'b0010;
  localparam logic [3:0] IID_MODEM   = 4'b0000;

  typedef struct packed {
    logic rbr_rd;
    logic thr_wr;
    logic dll_wr;
    logic dlm_wr;
    logic ier_wr;
    logic iir_rd;
    logic fcr_wr;
    logic lcr_wr;
    logic mcr_wr;
    logic lsr_rd;
    logic msr_rd;
    logic scr_wr;
  } acc_s;
endpackage

// File: rtl/uart_regif_rstsync.sv
`timescale 1ns/1ps
module uart_regif_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/uart_regif_decode.sv
`timescale 1ns/1ps
module uart_regif_decode
  import uart_regif_pkg::*;
#(
  parameter int unsigned OFS_W = 4
) (
  input  logic             sel,
  input  logic             strobe,
  input  logic             write,
  input  logic [OFS_W-1:0] ofs,
  input  logic             dlab,
  output acc_s             acc,
  output logic             rd_hit,
  output reg_ofs_e         rd_ofs
);
  logic     in_map, wr, rd;
  reg_ofs_e idx;

  assign in_map = (ofs >> 3) == '0;
  assign idx    = reg_ofs_e'(ofs[2:0]);
  assign wr     = sel & strobe & write & in_map;
  assign rd     = sel & strobe & ~write & in_map;

  always_comb begin
    acc        = '0;
    acc.rbr_rd = rd & (idx == OFS_DATA) & ~dlab;
    acc.thr_wr = wr & (idx == OFS_DATA) & ~dlab;
    acc.dll_wr = wr & (idx == OFS_DATA) & dlab;
    acc.dlm_wr = wr & (idx == OFS_IER) & dlab;
    acc.ier_wr = wr & (idx == OFS_IER) & ~dlab;
    acc.iir_rd = rd & (idx == OFS_IIR);
    acc.fcr_wr = wr & (idx == OFS_IIR);
    acc.lcr_wr = wr & (idx == OFS_LCR);
    acc.mcr_wr = wr & (idx == OFS_MCR);
    acc.lsr_rd = rd & (idx == OFS_LSR);
    acc.msr_rd = rd & (idx == OFS_MSR);
    acc.scr_wr = wr & (idx == OFS_SCR);
  end

  assign rd_hit = rd;
  assign rd_ofs = idx;

  // R2: a single access never raises two register strobes
  always_comb begin
    p_one_strobe_r2: assert ($onehot0(acc)) else $error("two register strobes at once");
  end
endmodule

// File: rtl/uart_regif_status.sv
`timescale 1ns/1ps
module uart_regif_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] err_set,
  input  logic       lsr_rd,
  input  logic [3:0] modem_in,
  input  logic       msr_rd,
  output logic [3:0] err_q,
  output logic [3:0] delta_q
);
  logic [3:0] err_d, delta_d, prev_q, delta_set;

  always_comb begin
    delta_set[0] = modem_in[0] ^ prev_q[0];
    delta_set[1] = modem_in[1] ^ prev_q[1];
    delta_set[2] = prev_q[2] & ~modem_in[2];
    delta_set[3] = modem_in[3] ^ prev_q[3];
    err_d   = (lsr_rd ? 4'b0 : err_q) | err_set;
    delta_d = (msr_rd ? 4'b0 : delta_q) | delta_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      delta_q <= '0;
      prev_q  <= '0;
    end else begin
      err_q   <= err_d;
      delta_q <= delta_d;
      prev_q  <= modem_in;
    end
  end

  p_lsr_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && err_set == 4'b0) |=> (err_q == 4'b0))
    else $error("line errors survive a status read");

  p_cts_delta_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_in[0] != $past(modem_in[0])) |=> delta_q[0])
    else $error("clear-to-send change not latched");
endmodule

// File: rtl/uart_regif_irq.sv
`timescale 1ns/1ps
module uart_regif_irq
  import uart_regif_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       fifo_en,
  input  logic       rx_ready,
  input  logic       rx_timeout,
  input  logic       err_any,
  input  logic       delta_any,
  input  logic       thr_empty,
  input  logic       iir_rd,
  input  logic       thr_wr,
  output logic       irq,
  output logic [3:0] iid
);
  logic thre_pend_q, thre_pend_d, empty_prev_q, ier1_prev_q;
  logic thre_set, thre_clr;
  logic c_line, c_to, c_rx, c_thre, c_ms;

  always_comb begin
    c_line = ier[2] & err_any;
    c_to   = ier[0] & fifo_en & rx_timeout;
    c_rx   = ier[0] & rx_ready;
    c_thre = ier[1] & thre_pend_q;
    c_ms   = ier[3] & delta_any;
    if      (c_line) iid = IID_LINE;
    else if (c_to)   iid = IID_TIMEOUT;
    else if (c_rx)   iid = IID_RXDATA;
    else if (c_thre) iid = IID_THRE;
    else if (c_ms)   iid = IID_MODEM;
    else             iid = IID_NONE;
    irq = c_line | c_to | c_rx | c_thre | c_ms;
    thre_set = thr_empty & (~empty_prev_q | (ier[1] & ~ier1_prev_q));
    thre_clr = thr_wr | (iir_rd & (iid == IID_THRE));
    thre_pend_d = thre_set | (thre_pend_q & ~thre_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_pend_q  <= 1'b0;
      empty_prev_q <= 1'b1;
      ier1_prev_q  <= 1'b0;
    end else begin
      thre_pend_q  <= thre_pend_d;
      empty_prev_q <= thr_empty;
      ier1_prev_q  <= ier[1];
    end
  end

  p_thre_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_empty) |=> !thre_pend_q)
    else $error("transmit-empty flag survives a transmit write");
endmodule

// File: rtl/uart_regif.sv
`timescale 1ns/1ps
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              strobe,
  input  logic              write,
  input  logic [ADDR_W-1:2] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        rx_data,
  input  logic              rx_ready,
  input  logic              rx_timeout,
  input  logic [3:0]        err_set,
  input  logic              thr_empty,
  input  logic              tx_idle,
  input  logic [3:0]        modem_in,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic [15:0]       divisor,
  output logic [6:0]        frame_cfg,
  output logic              fifo_en,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              irq
);
  localparam int unsigned OFS_W = ADDR_W - 2;

  logic       rst_n_s;
  acc_s       acc;
  logic       rd_hit;
  reg_ofs_e   rd_ofs;
  logic [3:0] ier_q, ier_d;
  logic [7:0] lcr_q, lcr_d, scr_q, scr_d;
  logic [4:0] mcr_q, mcr_d;
  logic       fifo_q, fifo_d, pop_q, push_q;
  logic [7:0] dll_q, dlm_q, thr_q;
  logic [3:0] err_q, delta_q, iid;
  logic [7:0] lsr, msr;

  uart_regif_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  uart_regif_decode #(.OFS_W(OFS_W)) u_dec (
    .sel(sel), .strobe(strobe), .write(write), .ofs(addr),
    .dlab(lcr_q[7]), .acc(acc), .rd_hit(rd_hit), .rd_ofs(rd_ofs)
  );

  uart_regif_status u_stat (
    .clk(clk), .rst_n(rst_n_s), .err_set(err_set), .lsr_rd(acc.lsr_rd),
    .modem_in(modem_in), .msr_rd(acc.msr_rd), .err_q(err_q), .delta_q(delta_q)
  );

  uart_regif_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .ier(ier_q), .fifo_en(fifo_q),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .err_any(|err_q),
    .delta_any(|delta_q), .thr_empty(thr_empty), .iir_rd(acc.iir_rd),
    .thr_wr(acc.thr_wr), .irq(irq), .iid(iid)
  );

  // next state of the control registers
  always_comb begin
    ier_d  = acc.ier_wr ? wdata[3:0] : ier_q;
    lcr_d  = acc.lcr_wr ? wdata      : lcr_q;
    mcr_d  = acc.mcr_wr ? wdata[4:0] : mcr_q;
    scr_d  = acc.scr_wr ? wdata      : scr_q;
    fifo_d = acc.fcr_wr ? wdata[0]   : fifo_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ier_q  <= '0;
      lcr_q  <= '0;
      mcr_q  <= '0;
      scr_q  <= '0;
      fifo_q <= 1'b0;
      pop_q  <= 1'b0;
      push_q <= 1'b0;
    end else begin
      ier_q  <= ier_d;
      lcr_q  <= lcr_d;
      mcr_q  <= mcr_d;
      scr_q  <= scr_d;
      fifo_q <= fifo_d;
      pop_q  <= acc.rbr_rd;
      push_q <= acc.thr_wr;
    end
  end

  // divisor and transmit byte are outside the reset domain on purpose
  always_ff @(posedge clk) begin
    if (acc.dll_wr) dll_q <= wdata;
    if (acc.dlm_wr) dlm_q <= wdata;
    if (acc.thr_wr) thr_q <= wdata;
  end

  assign lsr = {|err_q, tx_idle, thr_empty, err_q, rx_ready};
  assign msr = {modem_in, delta_q};

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      unique case (rd_ofs)
        OFS_DATA: rdata = lcr_q[7] ? dll_q : rx_data;
        OFS_IER:  rdata = lcr_q[7] ? dlm_q : {4'b0, ier_q};
        OFS_IIR:  rdata = {fifo_q, fifo_q, 2'b00, iid};
        OFS_LCR:  rdata = lcr_q;
        OFS_MCR:  rdata = {3'b000, mcr_q};
        OFS_LSR:  rdata = lsr;
        OFS_MSR:  rdata = msr;
        OFS_SCR:  rdata = scr_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign rx_pop    = pop_q;
  assign tx_push   = push_q;
  assign tx_data   = thr_q;
  assign divisor   = {dlm_q, dll_q};
  assign frame_cfg = lcr_q[6:0];
  assign fifo_en   = fifo_q;
  assign dtr_n     = ~mcr_q[0];
  assign rts_n     = ~mcr_q[1];

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq |-> (ier_q != 4'b0))
    else $error("interrupt raised with no enable set");

  p_reset_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$past(rst_n_s) |-> (rts_n && dtr_n && !irq && !tx_push && !rx_pop))
    else $error("outputs not at reset levels on reset exit");
endmodule

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;
  logic        clk = 1'b0;
  logic        rst_n, sel, strobe, write;
  logic [5:2]  addr;
  logic [7:0]  wdata, rdata, rx_data, tx_data;
  logic        rx_ready, rx_timeout, thr_empty, tx_idle;
  logic [3:0]  err_set, modem_in;
  logic        rx_pop, tx_push, fifo_en, rts_n, dtr_n, irq;
  logic [15:0] divisor;
  logic [6:0]  frame_cfg;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  uart_regif uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .strobe(strobe), .write(write),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout), .err_set(err_set),
    .thr_empty(thr_empty), .tx_idle(tx_idle), .modem_in(modem_in),
    .rx_pop(rx_pop), .tx_push(tx_push), .tx_data(tx_data), .divisor(divisor),
    .frame_cfg(frame_cfg), .fifo_en(fifo_en), .rts_n(rts_n), .dtr_n(dtr_n),
    .irq(irq)
  );

  typedef struct packed {
    logic       wr;
    logic [3:0] ofs;
    logic [7:0] data;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd7,  8'hA5, 4'd13}, '{1'b0, 4'd7,  8'hA5, 4'd13}, // R13 scratch
    '{1'b1, 4'd4,  8'h13, 4'd13}, '{1'b0, 4'd4,  8'h13, 4'd13}, // R13 modem ctl
    '{1'b1, 4'd3,  8'h1B, 4'd4},  '{1'b0, 4'd3,  8'h1B, 4'd4},
    '{1'b0, 4'd8,  8'h00, 4'd1},                                 // R1 unmapped read
    '{1'b1, 4'd15, 8'hFF, 4'd1},  '{1'b0, 4'd7,  8'hA5, 4'd1},   // R1 no alias
    '{1'b1, 4'd3,  8'h9B, 4'd4},                                 // R4 bank switch
    '{1'b1, 4'd0,  8'h34, 4'd4},  '{1'b1, 4'd1,  8'h12, 4'd4},
    '{1'b0, 4'd0,  8'h34, 4'd4},  '{1'b0, 4'd1,  8'h12, 4'd4},
    '{1'b1, 4'd3,  8'h1B, 4'd4},  '{1'b0, 4'd1,  8'h00, 4'd4},   // R4 enables back
    '{1'b0, 4'd2,  8'h01, 4'd8}                                  // R8 none pending
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic acc(input logic wr, input logic [3:0] ofs, input logic [7:0] d,
                     output logic [7:0] r);
    @(negedge clk);
    sel = 1'b1; strobe = 1'b1; write = wr; addr = ofs; wdata = d;
    #1 r = rdata;
    @(negedge clk);
    sel = 1'b0; strobe = 1'b0; write = 1'b0; wdata = '0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; sel = 0; strobe = 0; write = 0; addr = '0; wdata = '0;
    rx_data = 8'h5A; rx_ready = 0; rx_timeout = 0; err_set = '0;
    thr_empty = 1'b1; tx_idle = 1'b1; modem_in = '0;
    cyc(3);
    chk("R3 reset rts_n/dtr_n/irq", {13'b0, rts_n, dtr_n, irq}, 16'h0006);
    @(negedge clk) rst_n = 1'b1;
    cyc(3);
    chk("R2 idle rdata", {8'h0, rdata}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].wr, VEC[i].ofs, VEC[i].data, r);
      if (!VEC[i].wr)
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), {8'h0, r}, {8'h0, VEC[i].data});
    end
    chk("R4 divisor output", divisor, 16'h1234);
    chk("R4 frame_cfg", {9'h0, frame_cfg}, 16'h001B);
    chk("R13 dtr_n rts_n low", {14'b0, dtr_n, rts_n}, 16'h0000);
    acc(1'b1, 4'd4, 8'h01, r);
    chk("R13 only dtr asserted", {14'b0, dtr_n, rts_n}, 16'h0001);

    // R2: select or strobe alone does nothing
    @(negedge clk); sel = 0; strobe = 1; write = 1; addr = 4'd7; wdata = 8'h11;
    @(negedge clk); sel = 1; strobe = 0; wdata = 8'h22;
    @(negedge clk); sel = 0; strobe = 0; write = 0;
    acc(1'b0, 4'd7, 8'h00, r);
    chk("R2 partial access ignored", {8'h0, r}, 16'h00A5);

    // R5: receive read and pop timing
    acc(1'b0, 4'd0, 8'h00, r);
    chk("R5 rbr data", {8'h0, r}, 16'h005A);
    chk("R5 pop after read", {15'b0, rx_pop}, 16'h0001);
    cyc(1);
    chk("R5 pop one cycle", {15'b0, rx_pop}, 16'h0000);
    acc(1'b1, 4'd3, 8'h83, r);
    acc(1'b0, 4'd0, 8'h00, r);
    chk("R5 divisor read", {8'h0, r}, 16'h0034);
    chk("R5 no pop on divisor read", {15'b0, rx_pop}, 16'h0000);
    acc(1'b1, 4'd3, 8'h03, r);

    // R12: transmit-empty pending
    acc(1'b1, 4'd1, 8'h02, r);
    cyc(1);
    chk("R12 set by enable edge", {15'b0, irq}, 16'h0001);
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R12 iir thre code", {8'h0, r}, 16'h0002);
    chk("R12 cleared by iir read", {15'b0, irq}, 16'h0000);
    @(negedge clk) thr_empty = 1'b0;
    @(negedge clk) thr_empty = 1'b1;
    cyc(1);
    chk("R12 set by empty rise", {15'b0, irq}, 16'h0001);
    acc(1'b1, 4'd0, 8'h77, r);
    chk("R12 cleared by thr write", {15'b0, irq}, 16'h0000);
    chk("R6 push and data", {7'b0, tx_push, tx_data}, 16'h0177);
    cyc(1);
    chk("R6 push one cycle", {15'b0, tx_push}, 16'h0000);

    // R7/R8/R10: priority and line status
    acc(1'b1, 4'd1, 8'h0F, r);
    chk("R7 all enabled nothing pending", {15'b0, irq}, 16'h0000);
    @(negedge clk) rx_ready = 1'b1;
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R8 rx data code", {8'h0, r}, 16'h0004);
    chk("R7 irq on rx data", {15'b0, irq}, 16'h0001);
    @(negedge clk) err_set = 4'b0010;
    @(negedge clk) err_set = 4'b0000;
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R8 line beats rx data", {8'h0, r}, 16'h0006);
    acc(1'b0, 4'd5, 8'h00, r);
    chk("R10 lsr with parity error", {8'h0, r}, 16'h00E5);
    acc(1'b0, 4'd5, 8'h00, r);
    chk("R10 errors cleared by read", {8'h0, r}, 16'h0061);
    @(negedge clk) rx_ready = 1'b0;
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R8 none after service", {8'h0, r}, 16'h0001);

    // R9: timeout only in FIFO mode
    @(negedge clk) rx_timeout = 1'b1;
    cyc(1);
    chk("R9 timeout ignored outside fifo mode", {15'b0, irq}, 16'h0000);
    acc(1'b1, 4'd2, 8'h01, r);
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R9 timeout code in fifo mode", {8'h0, r}, 16'h00CC);
    chk("R9 fifo_en output", {15'b0, fifo_en}, 16'h0001);
    @(negedge clk) rx_timeout = 1'b0;
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R8 fifo bits with none", {8'h0, r}, 16'h00C1);
    acc(1'b1, 4'd2, 8'h00, r);

    // R11: modem deltas
    @(negedge clk) modem_in = 4'b0001;
    cyc(1);
    acc(1'b0, 4'd2, 8'h00, r);
    chk("R8 modem code", {8'h0, r}, 16'h0000);
    acc(1'b0, 4'd6, 8'h00, r);
    chk("R11 cts delta", {8'h0, r}, 16'h0011);
    chk("R11 irq cleared by msr read", {15'b0, irq}, 16'h0000);
    @(negedge clk) modem_in = 4'b0101;
    cyc(1);
    acc(1'b0, 4'd6, 8'h00, r);
    chk("R11 ri rise not latched", {8'h0, r}, 16'h0050);
    @(negedge clk) modem_in = 4'b0001;
    cyc(1);
    acc(1'b0, 4'd6, 8'h00, r);
    chk("R11 ri fall latched", {8'h0, r}, 16'h0014);

    // R3: reset scope
    acc(1'b1, 4'd7, 8'h3C, r);
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R3 async reset levels", {13'b0, rts_n, dtr_n, irq}, 16'h0006);
    @(negedge clk) rst_n = 1'b1; rx_ready = 1'b1;
    cyc(3);
    chk("R3 irq low with rx ready", {15'b0, irq}, 16'h0000);
    acc(1'b0, 4'd7, 8'h00, r);
    chk("R3 scratch cleared", {8'h0, r}, 16'h0000);
    acc(1'b0, 4'd3, 8'h00, r);
    chk("R3 lcr cleared", {8'h0, r}, 16'h0000);
    acc(1'b0, 4'd1, 8'h00, r);
    chk("R3 ier cleared", {8'h0, r}, 16'h0000);
    chk("R3 divisor kept", divisor, 16'h1234);
    chk("R3 tx byte kept", {8'h0, tx_data}, 16'h0077);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule